// File: doc/BRIEF.md
# I2C Bus-Lock Recovery Unit

This unit frees an I2C bus on which a slave has been left holding the data line low, for example after a reset in the middle of a byte or after an aborted transfer. Software or a bus controller fires a one-cycle start pulse. The unit first watches both lines for a fixed observation window. It declares the bus locked only if the data line stays low while the clock line stays high for the whole window. A data line that goes high, or a clock line that another master pulls low, shows normal traffic, and the unit then ends at once without touching the bus.

On a lock, the unit pulses the clock line through an open-drain pull-low output. Each pulse is one half-period low followed by one half-period released. At the end of every released half it samples the data line. It stops as soon as the line reads high, or after a bounded number of pulses. It then reports whether a lock was seen and whether the data line was still low after the last pulse. The unit never drives the data line, and it does not generate START or STOP conditions. Both line inputs are assumed to be synchronised to the clock already, and the half-period count must be held steady while a run is in progress.

Top module: `i2cUnstick`

## Requirements
- R1: After reset, sclPullLow, done, lockSeen and stuckAfter are all 0.
- R2: After start, the unit finishes with a one-cycle done and lockSeen = 0, with no clock pulse, when sdaIn = 1 or sclIn = 0 in any cycle of the observation window. done rises on the clock edge after that cycle.
- R3: A lock is declared only after LOCK_HALVES*H consecutive cycles with sdaIn = 0 and sclIn = 1, where H is the half-period in clock cycles. The first pull-low cycle, and lockSeen = 1, follow on the next edge.
- R4: Each clock pulse holds sclPullLow = 1 for exactly H cycles and then sclPullLow = 0 for H cycles.
- R5: If sdaIn = 1 in the last cycle of a released half, pulsing stops: done follows on the next edge, with stuckAfter = 0.
- R6: At most MAX_PULSES pulses are sent. If sdaIn is still 0 at the end of the last pulse, the unit finishes with stuckAfter = 1.
- R7: sclPullLow is 0 while idle, while observing and while done is high, so the clock line is released on completion.
- R8: A start pulse that arrives while a run is in progress is ignored.
- R9: A halfPeriod value of 0 behaves as a value of 1 (a one-cycle half-period). Otherwise H = halfPeriod.
- R10: lockSeen and stuckAfter hold their values from the end of a run until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a check-and-recover run |
| sclIn | input | 1 | Sampled level of the clock line |
| sdaIn | input | 1 | Sampled level of the data line |
| halfPeriod | input | CNT_W | Half-period length in clock cycles (0 treated as 1) |
| sclPullLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| done | output | 1 | One-cycle pulse at the end of a run |
| lockSeen | output | 1 | The last run found the bus locked |
| stuckAfter | output | 1 | The data line was still low after the last pulse |

## Verification
On every cycle, the embedded assertions check four things. done lasts a single cycle. The clock line is released whenever done is high. A pull-low never ends before its half-period tick. The observation and pulse counters stay inside their bounds, and a stuck report never appears without a lock. The exact cycle in which the window closes, the length of each half, the early exit on a released data line, the tenth-pulse limit, the handling of a zero half-period and the ignoring of a start during a run all depend on the line stimulus. Only the bench's scenarios can show these, by comparing every output against the reference model on every clock.

// File: rtl/unstickPkg.sv
package unstickPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WATCH,
    PH_LOW,
    PH_HIGH,
    PH_DONE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;       // restart the half-period timer
    logic clearCounts;  // zero window and pulse counters
    logic bumpWatch;    // one more stuck half-period observed
    logic bumpPulse;    // one more pulse completed
  } strobe_t;

endpackage

// File: rtl/unstickTimer.sv
module unstickTimer
  import unstickPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOCK_HALVES = 10,
  parameter int MAX_PULSES  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] halfPeriod,
  input  strobe_t          strobe,
  output logic             tick,
  output logic             watchLast,
  output logic             pulseLast
);

  localparam int WATCH_W = $clog2(LOCK_HALVES + 1);
  localparam int PULSE_W = $clog2(MAX_PULSES + 1);
  localparam logic [WATCH_W-1:0] WATCH_END = WATCH_W'(LOCK_HALVES - 1);
  localparam logic [PULSE_W-1:0] PULSE_END = PULSE_W'(MAX_PULSES - 1);

  logic [CNT_W-1:0]   halfCnt;
  logic [CNT_W-1:0]   loadVal;
  logic [WATCH_W-1:0] watchCnt;
  logic [PULSE_W-1:0] pulseCnt;

  // a zero request behaves as a one-cycle half-period
  assign loadVal = (halfPeriod == '0) ? '0 : halfPeriod - 1'b1;
  assign tick    = (halfCnt == '0);

  // free-running half-period timer, auto-reloading on each tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              halfCnt <= '0;
    else if (strobe.reload) halfCnt <= loadVal;
    else if (tick)          halfCnt <= loadVal;
    else                    halfCnt <= halfCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   watchCnt <= '0;
    else if (strobe.clearCounts) watchCnt <= '0;
    else if (strobe.bumpWatch)   watchCnt <= watchCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pulseCnt <= '0;
    else if (strobe.clearCounts) pulseCnt <= '0;
    else if (strobe.bumpPulse)   pulseCnt <= pulseCnt + 1'b1;
  end

  assign watchLast = (watchCnt == WATCH_END);
  assign pulseLast = (pulseCnt == PULSE_END);

  // R3: the observation count never runs past the window
  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    watchCnt < WATCH_W'(LOCK_HALVES));

  // R6: the pulse count never runs past the pulse limit
  a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt < PULSE_W'(MAX_PULSES));

endmodule

// File: rtl/unstickCtrl.sv
module unstickCtrl
  import unstickPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    tick,
  input  logic    watchLast,
  input  logic    pulseLast,
  output strobe_t strobe,
  output logic    sclPullLow,
  output logic    done,
  output logic    lockSeen,
  output logic    stuckAfter
);

  phase_t phase, phaseNext;
  logic   setLock, clrStatus, latchStuck;

  always_comb begin
    phaseNext  = phase;
    strobe     = '0;
    setLock    = 1'b0;
    clrStatus  = 1'b0;
    latchStuck = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          strobe.reload      = 1'b1;
          strobe.clearCounts = 1'b1;
          clrStatus          = 1'b1;
          phaseNext          = PH_WATCH;
        end
      end
      PH_WATCH: begin
        if (sdaIn || !sclIn) begin
          phaseNext = PH_DONE;       // normal traffic, not a lock
        end else if (tick) begin
          if (watchLast) begin
            setLock   = 1'b1;
            phaseNext = PH_LOW;
          end else begin
            strobe.bumpWatch = 1'b1;
          end
        end
      end
      PH_LOW: begin
        if (tick) phaseNext = PH_HIGH;
      end
      PH_HIGH: begin
        if (tick) begin
          if (sdaIn || pulseLast) begin
            latchStuck = 1'b1;
            phaseNext  = PH_DONE;
          end else begin
            strobe.bumpPulse = 1'b1;
            phaseNext        = PH_LOW;
          end
        end
      end
      PH_DONE: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockSeen   <= 1'b0;
      stuckAfter <= 1'b0;
    end else begin
      if (clrStatus) begin
        lockSeen   <= 1'b0;
        stuckAfter <= 1'b0;
      end
      if (setLock)    lockSeen   <= 1'b1;
      if (latchStuck) stuckAfter <= !sdaIn;
    end
  end

  assign sclPullLow = (phase == PH_LOW);
  assign done       = (phase == PH_DONE);

  // R2: completion is signalled for a single cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: the clock line is released whenever a run completes
  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !sclPullLow);

  // R4: a pull-low half only ends on a timer tick
  a_r4_low_holds: assert property (@(posedge clk) disable iff (!rstN)
    (sclPullLow && !tick) |=> sclPullLow);

  // R3: the lock flag appears together with the first pull-low
  a_r3_lock_with_pull: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockSeen) |-> sclPullLow);

  // R6: a stuck report is only possible after a lock
  a_r6_stuck_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    stuckAfter |-> lockSeen);

endmodule

// File: rtl/i2cUnstick.sv
module i2cUnstick
  import unstickPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOCK_HALVES = 10,
  parameter int MAX_PULSES  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic             sclPullLow,
  output logic             done,
  output logic             lockSeen,
  output logic             stuckAfter
);

  strobe_t strobe;
  logic    tick, watchLast, pulseLast;

  unstickTimer #(
    .CNT_W      (CNT_W),
    .LOCK_HALVES(LOCK_HALVES),
    .MAX_PULSES (MAX_PULSES)
  ) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .halfPeriod(halfPeriod),
    .strobe    (strobe),
    .tick      (tick),
    .watchLast (watchLast),
    .pulseLast (pulseLast)
  );

  unstickCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .tick      (tick),
    .watchLast (watchLast),
    .pulseLast (pulseLast),
    .strobe    (strobe),
    .sclPullLow(sclPullLow),
    .done      (done),
    .lockSeen  (lockSeen),
    .stuckAfter(stuckAfter)
  );

endmodule

// File: tb/i2cUnstick_bench.sv
`timescale 1ns/1ps
module i2cUnstick_bench;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startDrv = 1'b0;
  logic             slaveHold = 1'b0;  // slave keeps data line low
  logic             sclHold = 1'b0;    // another master keeps clock low
  logic [CNT_W-1:0] hp = 16'd3;
  logic             sclPullLow, done, lockSeen, stuckAfter;
  logic             sclIn, sdaIn;

  assign sclIn = !(sclPullLow || sclHold);
  assign sdaIn = !slaveHold;

  i2cUnstick #(.CNT_W(CNT_W)) u_i2cUnstick (
    .clk(clk), .rstN(rstN), .start(startDrv), .sclIn(sclIn), .sdaIn(sdaIn),
    .halfPeriod(hp), .sclPullLow(sclPullLow), .done(done),
    .lockSeen(lockSeen), .stuckAfter(stuckAfter)
  );

  always #2 clk = !clk;  // 250 MHz

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // behavioural reference: phase, elapsed stuck cycles, position in pulse
  int  mPh = 0;        // 0 idle, 1 watch, 2 pulsing, 3 done
  int  mEl = 0;
  int  mPos = 0;
  int  mPulse = 0;
  bit  mLock = 0;
  bit  mStuck = 0;

  function automatic int effH();
    return (hp == 0) ? 1 : int'(hp);
  endfunction

  function automatic bit expPull();
    return (mPh == 2) && (mPos < effH());
  endfunction

  always @(posedge clk) begin
    bit seenScl;
    seenScl = !(expPull() || sclHold);
    if (!rstN) begin
      mPh = 0; mEl = 0; mPos = 0; mPulse = 0; mLock = 0; mStuck = 0;
    end else begin
      case (mPh)
        0: if (startDrv) begin
             mPh = 1; mEl = 0; mLock = 0; mStuck = 0;
           end
        1: if (sdaIn || !seenScl) mPh = 3;
           else begin
             mEl++;
             if (mEl == 10 * effH()) begin
               mPh = 2; mLock = 1; mPos = 0; mPulse = 0;
             end
           end
        2: if (mPos == 2 * effH() - 1) begin
             mPulse++;
             if (sdaIn || mPulse == 10) begin
               mPh = 3; mStuck = !sdaIn;
             end else mPos = 0;
           end else mPos++;
        default: mPh = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(sclPullLow == expPull(), "R4 sclPullLow", sclPullLow, expPull());
      check(done == (mPh == 3), "R2 done", done, mPh == 3);
      check(lockSeen == mLock, "R3 lockSeen", lockSeen, mLock);
      check(stuckAfter == mStuck, "R6 stuckAfter", stuckAfter, mStuck);
    end
  end

  task automatic kick();
    @(negedge clk) startDrv = 1'b1;
    @(negedge clk) startDrv = 1'b0;
  endtask

  // run until done; slave releases after relPulses pulses (-1 never) or
  // after relCycle cycles (-1 never); pokeAt re-fires start mid-run
  task automatic runRun(input int relPulses, input int relCycle, input int pokeAt,
                        output int pulses);
    bit prevPull = 1'b0;
    pulses = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (sclPullLow && !prevPull) pulses++;
      prevPull = sclPullLow;
      if (done) break;
      startDrv = (cyc == pokeAt);
      if (relCycle >= 0 && cyc >= relCycle) slaveHold = 1'b0;
      if (relPulses >= 0 && pulses >= relPulses && !sclPullLow) slaveHold = 1'b0;
    end
    startDrv = 1'b0;
  endtask

  initial begin
    int np;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!sclPullLow && !done && !lockSeen && !stuckAfter, "R1 reset outputs",
          {sclPullLow, done, lockSeen, stuckAfter}, 0);

    // R2: idle bus, data line high
    kick(); runRun(-1, -1, -1, np);
    check(np == 0 && !lockSeen, "R2 free bus no pulses", np, 0);

    // R2: data low but another master holds clock low
    slaveHold = 1; sclHold = 1;
    kick(); runRun(-1, -1, -1, np);
    check(np == 0 && !lockSeen, "R2 clock low is traffic", np, 0);
    sclHold = 0;

    // R2/R3: data released inside the window (after 5 half-periods)
    slaveHold = 1;
    kick(); runRun(-1, 13, -1, np);
    check(np == 0 && !lockSeen, "R3 short low not a lock", np, 0);

    // R5: stuck, slave lets go after 3 pulses
    slaveHold = 1;
    kick(); runRun(3, -1, -1, np);
    check(np == 3 && lockSeen && !stuckAfter, "R5 early stop pulses", np, 3);

    // R10: status holds after the run
    repeat (5) @(negedge clk);
    check(lockSeen && !stuckAfter, "R10 status held", lockSeen, 1);

    // R6 + R8: permanently stuck, stray start during pulsing
    slaveHold = 1;
    kick(); runRun(-1, -1, 40, np);
    check(np == 10, "R6 pulse limit", np, 10);
    check(stuckAfter && lockSeen, "R6 still stuck reported", stuckAfter, 1);
    check(!sclPullLow, "R7 released at end", sclPullLow, 0);
    repeat (3) @(negedge clk);
    check(!sclPullLow && !done, "R8 stray start ignored", done, 0);

    // R10: new start clears status
    slaveHold = 0;
    kick(); runRun(-1, -1, -1, np);
    check(!lockSeen && !stuckAfter, "R10 cleared by start", lockSeen, 0);

    // R9: zero half-period acts as one cycle
    hp = 0; slaveHold = 1;
    kick(); runRun(1, -1, -1, np);
    check(np == 1 && lockSeen && !stuckAfter, "R9 zero half-period", np, 1);

    // R4: one-cycle half-period, stuck for two pulses
    hp = 1; slaveHold = 1;
    kick(); runRun(2, -1, -1, np);
    check(np == 2 && !stuckAfter, "R4 unit half-period", np, 2);

    // R6: longer half-period, never released
    hp = 5; slaveHold = 1;
    kick(); runRun(-1, -1, -1, np);
    check(np == 10 && stuckAfter, "R6 long half-period limit", np, 10);
    slaveHold = 0;

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule